// File: doc/BRIEF.md
# Button-Stepped Pacing Tick Generator

This block makes a single-cycle enable pulse that paces a slower state machine, for example a scanning light pattern. A free-running counter climbs from zero to a terminal value. When it reaches that value the pulse fires and the counter starts over, so pulses are spaced one cycle more than the terminal value apart.

A raw active-low push-button selects one of four speed levels. Each accepted press moves to the next level: base rate, then twice, four times and eight times the base rate, and then back to the base rate. The button is brought into the clock domain through two flops. Its level is accepted only after it has stayed unchanged for a set number of cycles.

The base period `BASE_PERIOD` is a power of two, at least 8, and sets the spacing at the slowest level. Level k uses terminal value `(BASE_PERIOD >> k) - 1`. The terminal value follows the selected level at once, and the counter is cleared whenever the level changes.

Top module: `rate_tick_gen`

## Requirements
- R1: While `rst_n` is low, `speed` is 0 and `tick` is low. After release the counter starts from zero, so the first `tick` comes `BASE_PERIOD-1` rising edges later.
- R2: `tick` is high for exactly one cycle, in the cycle where the counter equals the terminal value. At the next edge the counter returns to zero.
- R3: Consecutive ticks are `(BASE_PERIOD >> speed)` cycles apart, because the terminal value is `(BASE_PERIOD >> speed) - 1`. With the default `BASE_PERIOD` of 16 the spacings are 16, 8, 4 and 2 for `speed` 0, 1, 2 and 3.
- R4: Each accepted press adds one to `speed`, wrapping from 3 to 0. The order 0, 1, 2, 3 means base rate, ×2, ×4 and ×8.
- R5: `key_n` passes two synchronizing flops. A new level is accepted only after it has held for `DEBOUNCE` consecutive cycles, so a low pulse shorter than that leaves `speed` unchanged.
- R6: Only the accepted high-to-low edge of the key advances `speed`. Holding the key low does not repeat, and releasing it does not advance.
- R7: The counter is cleared on the edge where `speed` changes. The first tick at the new level therefore comes exactly `(BASE_PERIOD >> speed) - 1` edges after that change.
- R8: In any cycle without a tick and without a level change, the counter goes up by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_n | input | 1 | Raw speed button, low while pressed |
| tick | output | 1 | One-cycle pacing pulse |
| speed | output | 2 | Current speed level, 0 is the base rate |

## Verification
The hardest case to reach is the counter clear at a level change. The counter has to be well past the new, smaller terminal value at that moment, and the bench has no direct control over when the press is accepted. The bench presses the key and waits at the clock for `speed` to move. It then counts edges to the next tick and requires exactly the new terminal value, which would be far larger if the counter had run on and wrapped. Debounce rejection is reached with a low pulse one cycle shorter than the acceptance window.

// File: rtl/rate_pkg.sv
package rate_pkg;
  // terminal count for speed level lvl: period halves per level
  function automatic int unsigned level_divider(input int unsigned period,
                                                input logic [1:0] lvl);
    return (period >> lvl) - 1;
  endfunction
endpackage

// File: rtl/key_sync.sv
module key_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic synced_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= raw_n;
      sync_q <= meta_q;
    end
  end

  assign synced_n = sync_q;
endmodule

// File: rtl/key_debounce.sv
module key_debounce #(
  parameter int unsigned DEBOUNCE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic synced_n,
  output logic level_n,
  output logic press
);
  localparam int unsigned CW = $clog2(DEBOUNCE + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE - 1);

  logic [CW-1:0] run_q;
  logic          level_q;
  logic          differ, accept;

  assign differ = (synced_n != level_q);
  assign accept = differ && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (!differ) begin
      run_q <= '0;
    end else if (accept) begin
      run_q   <= '0;
      level_q <= synced_n;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_n = level_q;
  // accepted falling edge of the active-low key
  assign press   = accept && level_q;

  // R5
  debounce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != LAST) |=> $stable(level_q));
  // R6
  press_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !level_q);
endmodule

// File: rtl/speed_step.sv
module speed_step (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press,
  output logic [1:0] level,
  output logic       changing
);
  logic [1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level_q <= 2'd0;
    else if (press)  level_q <= level_q + 2'd1;
  end

  assign level    = level_q;
  assign changing = press;

  // R4
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> (level_q == 2'($past(level_q) + 2'd1)));
  // R6
  no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !press |=> $stable(level_q));
endmodule

// File: rtl/pace_counter.sv
module pace_counter #(
  parameter int unsigned BASE_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] level,
  input  logic       clear,
  output logic       tick
);
  import rate_pkg::*;
  localparam int unsigned CW = $clog2(BASE_PERIOD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;
  logic          hit;

  assign term = CW'(level_divider(BASE_PERIOD, level));
  assign hit  = (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear || hit)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = hit;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term);
  // R2
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
  parameter int unsigned BASE_PERIOD = 16,
  parameter int unsigned DEBOUNCE    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_n,
  output logic       tick,
  output logic [1:0] speed
);
  logic key_synced_n;
  logic key_level_n;
  logic key_press;
  logic level_changing;
  logic [1:0] level;

  key_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_n    (key_n),
    .synced_n (key_synced_n)
  );

  key_debounce #(.DEBOUNCE(DEBOUNCE)) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .synced_n (key_synced_n),
    .level_n  (key_level_n),
    .press    (key_press)
  );

  speed_step u_speed (
    .clk      (clk),
    .rst_n    (rst_n),
    .press    (key_press),
    .level    (level),
    .changing (level_changing)
  );

  pace_counter #(.BASE_PERIOD(BASE_PERIOD)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .level (level),
    .clear (level_changing),
    .tick  (tick)
  );

  assign speed = level;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (speed == 2'd0 && !tick));
  // R6
  release_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_level_n && $past(key_level_n)) |-> $stable(speed));
endmodule

// File: tb/sim_rate_tick_gen.sv
`timescale 1ns/1ps
module sim_rate_tick_gen;
  localparam int unsigned P   = 16;
  localparam int unsigned DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_n = 1'b1;
  logic tick;
  logic [1:0] speed;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rate_tick_gen #(.BASE_PERIOD(P), .DEBOUNCE(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .tick(tick), .speed(speed)
  );

  function automatic int exp_period(input int lvl);
    return P / (1 << lvl);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges_to_tick(output int n);
    n = 0;
    while (!tick && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 speed in reset", speed, 0);
    check("R1 tick in reset", tick, 0);
    rst_n = 1'b1;
    begin
      int n;
      edges_to_tick(n);
      check("R1 first tick delay", n, P - 1);
    end
    @(negedge clk);
    check("R2 tick one cycle", tick, 0);
  endtask

  task automatic t_interval(input int lvl);
    int n;
    edges_to_tick(n);
    @(negedge clk);
    check("R2 tick width", tick, 0);
    n = 1;
    edges_to_tick(n);
    check("R3 tick spacing", n + 1, exp_period(lvl));
  endtask

  task automatic t_press(input int exp_lvl);
    int old = speed;
    int w = 0;
    int n;
    @(negedge clk);
    key_n = 1'b0;
    while (speed == old && w < 40) begin
      @(negedge clk);
      w++;
    end
    check("R4 speed after press", speed, exp_lvl);
    edges_to_tick(n);
    check("R7 first tick after change", n, exp_period(exp_lvl) - 1);
    repeat (3 * DEB) @(negedge clk);
    check("R6 hold no repeat", speed, exp_lvl);
    key_n = 1'b1;
    repeat (DEB + 6) @(negedge clk);
    check("R6 release no step", speed, exp_lvl);
    t_interval(exp_lvl);
  endtask

  task automatic t_glitch();
    int old = speed;
    @(negedge clk);
    key_n = 1'b0;
    repeat (DEB - 1) @(negedge clk);
    key_n = 1'b1;
    repeat (DEB + 6) @(negedge clk);
    check("R5 short pulse ignored", speed, old);
  endtask

  initial begin
    t_reset();
    t_interval(0);
    t_glitch();
    t_press(1);
    t_press(2);
    t_glitch();
    t_press(3);
    t_press(0);
    t_press(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule